// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, cycle by cycle, which of four hardware thread contexts feeds the next instruction fetch of a single-issue pipeline. Every context keeps its own program counter inside the block. The selected context's PC is presented together with its thread number and a valid flag. When that instruction issues, only that context's PC steps forward. A redirect port lets the pipeline overwrite the PC of any one context, for example after a taken branch.

A mode input picks between two scheduling policies. In interleaved (fine) mode the selector rotates round-robin every cycle, skipping contexts that are not eligible. In switch-on-event (coarse) mode it stays on one context until that context reports a long-latency stall. It then raises a one-cycle flush request, moves to the next eligible context in rotation order, and holds issue off for a fixed refill time.

A context is eligible when its ready flag is 1 and its stall flag is 0. The eligibility, mode and stall inputs are sampled combinationally. Selection state and PCs change only at the clock edge.

Top module: `hmt_thread_sel`

## Requirements
- R1: After reset, context t holds PC = START_BASE + t*START_STRIDE (defaults 0x1000 and 0x1000). The refill window is clear. In fine mode with all four contexts eligible, the first instruction issues from context 0.
- R2: In fine mode, the search starts at the context after the last one that issued and wraps from 3 to 0. It skips every context with ready=0 or stall=1. If that last context is the only eligible one, it issues again.
- R3: In fine mode, whenever two or more contexts are eligible on two consecutive issuing cycles, the second cycle issues from a different context than the first.
- R4: When no instruction can issue outside a flush or refill cycle, issue_valid_o=0 and idle_o=1, and no PC changes. In fine mode this happens exactly when no context is eligible.
- R5: At each edge where issue_valid_o=1, the PC of the issuing context grows by PC_STEP (4). No other context's PC changes.
- R6: When redir_en_i=1, the PC of context redir_tid_i takes redir_pc_i at the edge. This overrides the increment of R5 for that context and leaves every other context as R5 gives it.
- R7: In coarse mode, while the current context is eligible and long_stall_i=0, it issues every cycle and no other context is chosen.
- R8: In coarse mode, if the current context is not eligible and long_stall_i=0, the cycle is idle (R4) and the current context is kept.
- R9: In coarse mode, long_stall_i=1 with another eligible context present raises flush_o for exactly one cycle with issue_valid_o=0. The new current context is the first eligible one after the old current context in rotation order, excluding the old one.
- R10: After a flush cycle, issue_valid_o stays 0 with idle_o=0 for REFILL_CYCLES (3) cycles. In the next cycle the new context issues if it is eligible.
- R11: In coarse mode, long_stall_i=1 with no other eligible context gives an idle cycle without flush, and the current context is kept.
- R12: In fine mode, long_stall_i has no effect: flush_o stays 0 and the rotation proceeds as R2 gives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | 0 = interleaved (fine), 1 = switch-on-event (coarse) |
| thr_ready_i | input | N_THREADS | Per-context ready flags |
| thr_stall_i | input | N_THREADS | Per-context stall flags |
| long_stall_i | input | 1 | Current context hit a long-latency stall (coarse mode) |
| redir_en_i | input | 1 | Write a context's PC this cycle |
| redir_tid_i | input | TID_W | Context whose PC is written |
| redir_pc_i | input | PC_W | New PC value |
| issue_valid_o | output | 1 | An instruction from sel_tid_o issues this cycle |
| sel_tid_o | output | TID_W | Selected context |
| sel_pc_o | output | PC_W | PC of the selected context |
| idle_o | output | 1 | Bubble: nothing issues and no flush or refill is in progress |
| flush_o | output | 1 | Pipeline flush request on a coarse-mode switch |

## Verification
The assertions check the following on every cycle:
- an issuing context is always eligible;
- idle never coincides with issue or flush;
- a flush lasts one cycle, comes only from a coarse-mode long stall, and is followed by a refill window with no issue;
- fine mode never issues the same context twice in a row while two or more are eligible;
- coarse mode never changes context between two issuing cycles.

Other behaviours can only be shown by the bench's scenarios:
- the exact rotation order;
- the choice of switch target, including wrap-around;
- the per-context PC values after increments, redirects and idle cycles;
- the cases with no switch target.

// File: rtl/hmt_pkg.sv
`timescale 1ns/1ps
package hmt_pkg;
  typedef enum logic {
    SEL_FINE   = 1'b0,
    SEL_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/hmt_rr_pick.sv
`timescale 1ns/1ps
// Round-robin finder: first set bit of mask_i strictly after after_i, wrapping.
module hmt_rr_pick #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     mask_i,
  input  logic [TID_W-1:0] after_i,
  output logic             found_o,
  output logic [TID_W-1:0] idx_o
);
  always_comb begin
    int slot;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      slot = (int'(after_i) + k) % N;
      if (!found_o && mask_i[slot]) begin
        found_o = 1'b1;
        idx_o   = TID_W'(slot);
      end
    end
  end
endmodule

// File: rtl/hmt_pc_bank.sv
`timescale 1ns/1ps
// One private PC per context; write port wins over increment.
module hmt_pc_bank #(
  parameter int               N            = 4,
  parameter int               TID_W        = 2,
  parameter int               PC_W         = 32,
  parameter logic [PC_W-1:0]  START_BASE   = 'h1000,
  parameter logic [PC_W-1:0]  START_STRIDE = 'h1000,
  parameter logic [PC_W-1:0]  PC_STEP      = 'h4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_en_i,
  input  logic [TID_W-1:0]        inc_tid_i,
  input  logic                    wr_en_i,
  input  logic [TID_W-1:0]        wr_tid_i,
  input  logic [PC_W-1:0]         wr_pc_i,
  output logic [N-1:0][PC_W-1:0]  pc_o
);
  for (genvar g = 0; g < N; g++) begin : g_ctx
    localparam logic [PC_W-1:0] START = START_BASE + PC_W'(g) * START_STRIDE;
    logic            hit_wr;
    logic            hit_inc;
    logic            pc_en;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_q;

    always_comb begin
      hit_wr  = wr_en_i  && (wr_tid_i  == TID_W'(g));
      hit_inc = inc_en_i && (inc_tid_i == TID_W'(g));
      pc_en   = hit_wr || hit_inc;
      if (hit_wr) pc_d = wr_pc_i;
      else        pc_d = pc_q + PC_STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= START;
      else if (pc_en) pc_q <= pc_d;
    end

    assign pc_o[g] = pc_q;
  end
endmodule

// File: rtl/hmt_refill_ctr.sv
`timescale 1ns/1ps
// Counts the refill window that follows a pipeline flush.
module hmt_refill_ctr #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    cnt_en = load_i || busy_o;
    if (load_i) cnt_d = CNT_W'(CYCLES);
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hmt_thread_sel.sv
`timescale 1ns/1ps
module hmt_thread_sel
  import hmt_pkg::*;
#(
  parameter int               N_THREADS     = 4,
  parameter int               PC_W          = 32,
  parameter logic [PC_W-1:0]  START_BASE    = 'h1000,
  parameter logic [PC_W-1:0]  START_STRIDE  = 'h1000,
  parameter logic [PC_W-1:0]  PC_STEP       = 'h4,
  parameter int               REFILL_CYCLES = 3,
  localparam int              TID_W         = $clog2(N_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic [N_THREADS-1:0] thr_ready_i,
  input  logic [N_THREADS-1:0] thr_stall_i,
  input  logic                 long_stall_i,
  input  logic                 redir_en_i,
  input  logic [TID_W-1:0]     redir_tid_i,
  input  logic [PC_W-1:0]      redir_pc_i,
  output logic                 issue_valid_o,
  output logic [TID_W-1:0]     sel_tid_o,
  output logic [PC_W-1:0]      sel_pc_o,
  output logic                 idle_o,
  output logic                 flush_o
);
  sel_mode_e                     mode;
  logic [N_THREADS-1:0]          eligible;
  logic [N_THREADS-1:0]          sw_mask;
  logic                          fine_found;
  logic [TID_W-1:0]              fine_idx;
  logic                          sw_found;
  logic [TID_W-1:0]              sw_idx;
  logic                          refill_busy;
  logic [TID_W-1:0]              last_q, last_d;
  logic [TID_W-1:0]              cur_q,  cur_d;
  logic                          ptr_en;
  logic [N_THREADS-1:0][PC_W-1:0] pc_all;

  assign mode     = sel_mode_e'(mode_i);
  assign eligible = thr_ready_i & ~thr_stall_i;
  assign sw_mask  = eligible & ~({{(N_THREADS-1){1'b0}}, 1'b1} << cur_q);

  hmt_rr_pick #(.N(N_THREADS), .TID_W(TID_W)) u_fine_pick (
    .mask_i  (eligible),
    .after_i (last_q),
    .found_o (fine_found),
    .idx_o   (fine_idx)
  );

  hmt_rr_pick #(.N(N_THREADS), .TID_W(TID_W)) u_switch_pick (
    .mask_i  (sw_mask),
    .after_i (cur_q),
    .found_o (sw_found),
    .idx_o   (sw_idx)
  );

  hmt_refill_ctr #(.CYCLES(REFILL_CYCLES)) u_refill (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (flush_o),
    .busy_o (refill_busy)
  );

  always_comb begin
    issue_valid_o = 1'b0;
    idle_o        = 1'b0;
    flush_o       = 1'b0;
    sel_tid_o     = cur_q;
    cur_d         = cur_q;
    last_d        = last_q;
    if (refill_busy) begin
      issue_valid_o = 1'b0;
    end else if (mode == SEL_COARSE) begin
      if (long_stall_i) begin
        if (sw_found) begin
          flush_o = 1'b1;
          cur_d   = sw_idx;
        end else begin
          idle_o  = 1'b1;
        end
      end else if (eligible[cur_q]) begin
        issue_valid_o = 1'b1;
      end else begin
        idle_o = 1'b1;
      end
    end else begin
      if (fine_found) begin
        issue_valid_o = 1'b1;
        sel_tid_o     = fine_idx;
      end else begin
        idle_o = 1'b1;
      end
    end
    if (issue_valid_o) begin
      last_d = sel_tid_o;
      cur_d  = sel_tid_o;
    end
    ptr_en = issue_valid_o || flush_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= TID_W'(N_THREADS - 1);
      cur_q  <= '0;
    end else if (ptr_en) begin
      last_q <= last_d;
      cur_q  <= cur_d;
    end
  end

  hmt_pc_bank #(
    .N            (N_THREADS),
    .TID_W        (TID_W),
    .PC_W         (PC_W),
    .START_BASE   (START_BASE),
    .START_STRIDE (START_STRIDE),
    .PC_STEP      (PC_STEP)
  ) u_pcs (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en_i  (issue_valid_o),
    .inc_tid_i (sel_tid_o),
    .wr_en_i   (redir_en_i),
    .wr_tid_i  (redir_tid_i),
    .wr_pc_i   (redir_pc_i),
    .pc_o      (pc_all)
  );

  assign sel_pc_o = pc_all[sel_tid_o];
endmodule

// File: rtl/hmt_thread_sel_chk.sv
`timescale 1ns/1ps
module hmt_thread_sel_chk #(
  parameter int N_THREADS     = 4,
  parameter int TID_W         = 2,
  parameter int REFILL_CYCLES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_i,
  input logic [N_THREADS-1:0] thr_ready_i,
  input logic [N_THREADS-1:0] thr_stall_i,
  input logic                 long_stall_i,
  input logic                 issue_valid_o,
  input logic [TID_W-1:0]     sel_tid_o,
  input logic                 idle_o,
  input logic                 flush_o
);
  localparam int WIN_W = $clog2(REFILL_CYCLES + 1);

  logic             armed_q;
  logic [WIN_W-1:0] win_q;
  logic [N_THREADS-1:0] elig;

  assign elig = thr_ready_i & ~thr_stall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      if (flush_o)            win_q <= WIN_W'(REFILL_CYCLES);
      else if (win_q != '0)   win_q <= win_q - WIN_W'(1);
    end
  end

  AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (thr_ready_i[sel_tid_o] && !thr_stall_i[sel_tid_o])); // R2
  AST_FINE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !mode_i && issue_valid_o && $past(issue_valid_o) && ($countones(elig) >= 2))
      |-> (sel_tid_o != $past(sel_tid_o))); // R3
  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!issue_valid_o && !flush_o)); // R4
  AST_FINE_IDLE_NONE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && idle_o) |-> (elig == '0)); // R4
  AST_COARSE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_i && $past(mode_i) && issue_valid_o && $past(issue_valid_o))
      |-> (sel_tid_o == $past(sel_tid_o))); // R7
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o); // R9
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (mode_i && long_stall_i && !issue_valid_o)); // R9
  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> (!issue_valid_o && !idle_o)); // R10
  AST_FINE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |-> !flush_o); // R12
endmodule

bind hmt_thread_sel hmt_thread_sel_chk #(
  .N_THREADS     (N_THREADS),
  .TID_W         (TID_W),
  .REFILL_CYCLES (REFILL_CYCLES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .thr_ready_i   (thr_ready_i),
  .thr_stall_i   (thr_stall_i),
  .long_stall_i  (long_stall_i),
  .issue_valid_o (issue_valid_o),
  .sel_tid_o     (sel_tid_o),
  .idle_o        (idle_o),
  .flush_o       (flush_o)
);

// File: tb/sim_hmt_thread_sel.sv
`timescale 1ns/1ps
module sim_hmt_thread_sel;
  logic        clk;
  logic        rst_n;
  logic        mode;
  logic [3:0]  ready;
  logic [3:0]  stall;
  logic        long_st;
  logic        redir_en;
  logic [1:0]  redir_tid;
  logic [31:0] redir_pc;
  logic        issue_valid_o;
  logic [1:0]  sel_tid_o;
  logic [31:0] sel_pc_o;
  logic        idle_o;
  logic        flush_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_pc [4];

  hmt_thread_sel u0 (
    .clk (clk), .rst_n (rst_n), .mode_i (mode),
    .thr_ready_i (ready), .thr_stall_i (stall), .long_stall_i (long_st),
    .redir_en_i (redir_en), .redir_tid_i (redir_tid), .redir_pc_i (redir_pc),
    .issue_valid_o (issue_valid_o), .sel_tid_o (sel_tid_o), .sel_pc_o (sel_pc_o),
    .idle_o (idle_o), .flush_o (flush_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge; outputs are checked mid-low phase.
  task automatic cyc(input bit ev, input int et, input bit ei, input bit ef,
                     input string req);
    #5;
    chk(req, "issue_valid", 32'(issue_valid_o), 32'(ev));
    chk(req, "idle", 32'(idle_o), 32'(ei));
    chk(req, "flush", 32'(flush_o), 32'(ef));
    if (ev) begin
      chk(req, "sel_tid", 32'(sel_tid_o), 32'(et));
      chk(req, "sel_pc", sel_pc_o, exp_pc[et]);
    end
    @(posedge clk);
    if (ev && !(redir_en && int'(redir_tid) == et)) exp_pc[et] += 32'h4; // R5
    if (redir_en) exp_pc[redir_tid] = redir_pc;                           // R6
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode = 1'b0; ready = 4'hF; stall = 4'h0; long_st = 1'b0;
    redir_en = 1'b0; redir_tid = 2'd0; redir_pc = 32'h0;
    for (int t = 0; t < 4; t++) exp_pc[t] = 32'h1000 + 32'(t) * 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, "R1");
  endtask

  task automatic t_fine_rr;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 2, 0, 0, "R3");
    cyc(1, 3, 0, 0, "R2"); cyc(1, 0, 0, 0, "R3");
  endtask

  task automatic t_fine_skip;
    stall = 4'b0100;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 3, 0, 0, "R2"); cyc(1, 0, 0, 0, "R2");
    cyc(1, 1, 0, 0, "R2"); cyc(1, 3, 0, 0, "R2");
    stall = 4'b0000; ready = 4'b1110;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 2, 0, 0, "R2"); cyc(1, 3, 0, 0, "R2");
    cyc(1, 1, 0, 0, "R2");
    ready = 4'hF;
  endtask

  task automatic t_idle;
    stall = 4'hF;
    cyc(0, 0, 1, 0, "R4"); cyc(0, 0, 1, 0, "R4");
    stall = 4'h0;
    cyc(1, 2, 0, 0, "R4");
  endtask

  task automatic t_fine_single;
    stall = 4'b1101;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 1, 0, 0, "R2"); cyc(1, 1, 0, 0, "R5");
    stall = 4'h0;
  endtask

  task automatic t_fine_long_ignored;
    long_st = 1'b1;
    cyc(1, 2, 0, 0, "R12"); cyc(1, 3, 0, 0, "R12");
    long_st = 1'b0;
  endtask

  task automatic t_redirect;
    redir_en = 1'b1; redir_tid = 2'd0; redir_pc = 32'h8000;
    cyc(1, 0, 0, 0, "R6");
    redir_tid = 2'd3; redir_pc = 32'h9000;
    cyc(1, 1, 0, 0, "R6");
    redir_en = 1'b0;
    cyc(1, 2, 0, 0, "R6"); cyc(1, 3, 0, 0, "R6"); cyc(1, 0, 0, 0, "R6");
  endtask

  task automatic t_coarse_hold;
    mode = 1'b1;
    cyc(1, 0, 0, 0, "R7"); cyc(1, 0, 0, 0, "R7"); cyc(1, 0, 0, 0, "R7");
  endtask

  task automatic t_coarse_short;
    stall = 4'b0001;
    cyc(0, 0, 1, 0, "R8"); cyc(0, 0, 1, 0, "R8");
    stall = 4'h0;
    cyc(1, 0, 0, 0, "R8");
  endtask

  task automatic t_coarse_switch;
    long_st = 1'b1; stall = 4'b0011;
    cyc(0, 0, 0, 1, "R9");
    long_st = 1'b0; stall = 4'h0;
    cyc(0, 0, 0, 0, "R10"); cyc(0, 0, 0, 0, "R10"); cyc(0, 0, 0, 0, "R10");
    cyc(1, 2, 0, 0, "R10"); cyc(1, 2, 0, 0, "R7");
  endtask

  task automatic t_coarse_noswitch;
    long_st = 1'b1; stall = 4'b1011;
    cyc(0, 0, 1, 0, "R11");
    long_st = 1'b0; stall = 4'h0;
    cyc(1, 2, 0, 0, "R11");
  endtask

  task automatic t_coarse_wrap;
    long_st = 1'b1; stall = 4'b1100;
    cyc(0, 0, 0, 1, "R9");
    long_st = 1'b0; stall = 4'h0;
    cyc(0, 0, 0, 0, "R10"); cyc(0, 0, 0, 0, "R10"); cyc(0, 0, 0, 0, "R10");
    cyc(1, 0, 0, 0, "R9");
  endtask

  task automatic t_back_fine;
    mode = 1'b0;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 2, 0, 0, "R5"); cyc(1, 3, 0, 0, "R5");
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_fine_rr;
    t_fine_skip;
    t_idle;
    t_fine_single;
    t_fine_long_ignored;
    t_redirect;
    t_coarse_hold;
    t_coarse_short;
    t_coarse_switch;
    t_coarse_noswitch;
    t_coarse_wrap;
    t_back_fine;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule